// File: doc/BRIEF.md
# Branch and Skip Condition Evaluator

This block decides, for one conditional control-flow instruction at a time, whether the instruction is taken. It also reports how far the program counter moves and how many cycles the instruction costs. Each request carries the 8-bit status byte and an instruction class. Depending on the class, it also carries a flag index or bit index, a named condition code, the byte under test from a register or I/O location, the equality result of a register compare, the 7-bit relative offset, and whether the next instruction is two words long. The answer is registered and appears one clock after the request is sampled.

Three kinds of branch are handled. A generic branch tests any status bit for set or for clear. A named branch uses one of sixteen condition codes, including the signed pair built from N XOR V. A taken branch moves the program counter by the sign-extended offset plus one and costs two cycles. A branch that is not taken moves it by one and costs one cycle.

There are five skip classes: skip on compare-equal, skip on register bit set or clear, and skip on I/O bit set or clear. A skip that is not taken moves the counter by one and costs one cycle. A taken skip moves it by 2 and costs 2 cycles when the instruction it jumps over is one word long, or by 3 and costs 3 cycles when that instruction is two words long. Fetch, the target adder of the core and the stack are outside the block.

Top module: `bse_eval`

## Requirements
- R1: While rst_ni is low, valid_o and taken_o are 0, pc_inc_o is 0 and cycles_o is 0.
- R2: A request sampled with valid_i high at a rising edge appears on the outputs after that edge, and valid_o is high for that one cycle. When valid_i is low at an edge, valid_o goes low and taken_o, pc_inc_o and cycles_o keep their previous values.
- R3: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Class 1 (generic branch on set) is taken when sreg_i[bit_idx_i] is 1. Class 2 (generic branch on clear) is taken when that bit is 0.
- R4: Class 3 (named branch) uses cond_i, where bit 0 of the code inverts the sense. Code 0 is taken on Z set and code 1 on Z clear. Codes 2 and 4 are taken on C set; codes 3 and 5 are taken on C clear. Code 6 is taken on N set and code 7 on N clear.
- R5: Code 8 is taken when N XOR V is 1 (signed less-than). Code 9 is taken when N XOR V is 0 (signed greater-or-equal).
- R6: Code 10 is taken on H set and code 11 on H clear. Code 12 is taken on T set and code 13 on T clear. Code 14 is taken on V set and code 15 on V clear.
- R7: A taken branch gives cycles_o=2 and pc_inc_o equal to the sign extension of offset_i (7-bit two's complement) plus 1. A branch that is not taken gives cycles_o=1 and pc_inc_o=1.
- R8: Class 4 (compare-skip) is taken when regs_eq_i is 1.
- R9: Using test_byte_i[bit_idx_i], class 5 (register bit clear) and class 7 (I/O bit clear) are taken when the bit is 0. Class 6 (register bit set) and class 8 (I/O bit set) are taken when the bit is 1.
- R10: A skip that is not taken gives cycles_o=1 and pc_inc_o=1. A taken skip gives cycles_o=2 and pc_inc_o=2 when next_two_word_i is 0, and cycles_o=3 and pc_inc_o=3 when next_two_word_i is 1.
- R11: Class 0 and classes 9 to 15 are never taken. They give cycles_o=1 and pc_inc_o=1 whatever the status byte and offset are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| class_i | input | 4 | Instruction class code |
| sreg_i | input | 8 | Status byte |
| bit_idx_i | input | 3 | Status flag index or tested bit index |
| cond_i | input | 4 | Named branch condition code |
| test_byte_i | input | 8 | Register or I/O byte for bit skips |
| regs_eq_i | input | 1 | Register compare found equal |
| next_two_word_i | input | 1 | Following instruction is two words |
| offset_i | input | 7 | Signed relative branch offset |
| valid_o | output | 1 | Result present this cycle |
| taken_o | output | 1 | Branch or skip taken |
| pc_inc_o | output | 16 | Program counter increment, two's complement |
| cycles_o | output | 2 | Cycle cost of the instruction |

## Verification
Every result has a latency of exactly one clock. The outcome of a request sampled at a rising edge is visible on all four result outputs right after that edge. The bench changes inputs on the falling edge and compares against its behavioural model on the next falling edge, which is half a cycle after the result registers load. Idle cycles are checked in the same slot to confirm that valid_o drops and that the held results do not move.

// File: rtl/bse_pkg.sv
package bse_pkg;
  // status byte bit positions
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;

  // condition pair that tests N xor V instead of a single flag
  localparam int PAIR_SIGNED = 4;

  typedef enum logic [3:0] {
    CLS_NONE        = 4'd0,
    CLS_BR_SET      = 4'd1,
    CLS_BR_CLR      = 4'd2,
    CLS_BR_COND     = 4'd3,
    CLS_SKIP_EQ     = 4'd4,
    CLS_SKIP_RB_CLR = 4'd5,
    CLS_SKIP_RB_SET = 4'd6,
    CLS_SKIP_IO_CLR = 4'd7,
    CLS_SKIP_IO_SET = 4'd8
  } cls_e;

  // flag tested by each condition pair; code bit 0 inverts
  function automatic int pair_flag(input int p);
    case (p)
      0:       return FLG_Z;
      1, 2:    return FLG_C;
      3:       return FLG_N;
      5:       return FLG_H;
      6:       return FLG_T;
      7:       return FLG_V;
      default: return FLG_Z;
    endcase
  endfunction
endpackage

// File: rtl/bse_flag_cond.sv
module bse_flag_cond import bse_pkg::*; #(
  parameter int SREG_W = 8,
  parameter int CC_W   = 4
) (
  input  logic [SREG_W-1:0] sreg_i,
  input  logic [CC_W-1:0]   code_i,
  output logic              hit_o
);
  localparam int NPAIR = 1 << (CC_W - 1);

  logic [NPAIR-1:0] pair_raw;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    if (p == PAIR_SIGNED) begin : g_sgn
      assign pair_raw[p] = sreg_i[FLG_N] ^ sreg_i[FLG_V];
    end else begin : g_bit
      assign pair_raw[p] = sreg_i[pair_flag(p)];
    end
  end

  assign hit_o = pair_raw[code_i[CC_W-1:1]] ^ code_i[0];
endmodule

// File: rtl/bse_branch_cond.sv
module bse_branch_cond import bse_pkg::*; #(
  parameter int SREG_W = 8,
  parameter int IDX_W  = $clog2(SREG_W),
  parameter int CLS_W  = 4,
  parameter int CC_W   = 4
) (
  input  logic [CLS_W-1:0]  class_i,
  input  logic [SREG_W-1:0] sreg_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [CC_W-1:0]   cond_i,
  output logic              is_branch_o,
  output logic              hit_o
);
  logic code_hit;
  logic sel_bit;

  bse_flag_cond #(.SREG_W(SREG_W), .CC_W(CC_W)) u_flag (
    .sreg_i (sreg_i),
    .code_i (cond_i),
    .hit_o  (code_hit)
  );

  assign sel_bit = sreg_i[bit_idx_i];

  always_comb begin
    is_branch_o = 1'b0;
    hit_o       = 1'b0;
    if (class_i == CLS_W'(CLS_BR_SET)) begin
      is_branch_o = 1'b1;
      hit_o       = sel_bit;
    end else if (class_i == CLS_W'(CLS_BR_CLR)) begin
      is_branch_o = 1'b1;
      hit_o       = ~sel_bit;
    end else if (class_i == CLS_W'(CLS_BR_COND)) begin
      is_branch_o = 1'b1;
      hit_o       = code_hit;
    end
  end
endmodule

// File: rtl/bse_skip_cond.sv
module bse_skip_cond import bse_pkg::*; #(
  parameter int SREG_W = 8,
  parameter int IDX_W  = $clog2(SREG_W),
  parameter int CLS_W  = 4
) (
  input  logic [CLS_W-1:0]  class_i,
  input  logic [SREG_W-1:0] test_byte_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              regs_eq_i,
  output logic              is_skip_o,
  output logic              hit_o
);
  logic bit_val;

  assign bit_val = test_byte_i[bit_idx_i];

  always_comb begin
    is_skip_o = 1'b1;
    hit_o     = 1'b0;
    case (class_i)
      CLS_W'(CLS_SKIP_EQ):     hit_o = regs_eq_i;
      CLS_W'(CLS_SKIP_RB_CLR),
      CLS_W'(CLS_SKIP_IO_CLR): hit_o = ~bit_val;
      CLS_W'(CLS_SKIP_RB_SET),
      CLS_W'(CLS_SKIP_IO_SET): hit_o = bit_val;
      default:                 is_skip_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bse_cost.sv
module bse_cost #(
  parameter int OFS_W    = 7,
  parameter int PC_INC_W = 16,
  parameter int CYC_W    = 2
) (
  input  logic                is_branch_i,
  input  logic                br_hit_i,
  input  logic                is_skip_i,
  input  logic                skip_hit_i,
  input  logic                two_word_i,
  input  logic [OFS_W-1:0]    offset_i,
  output logic                taken_o,
  output logic [PC_INC_W-1:0] pc_inc_o,
  output logic [CYC_W-1:0]    cycles_o
);
  localparam logic [PC_INC_W-1:0] INC_ONE = PC_INC_W'(1);
  localparam int                  EXT_W   = PC_INC_W - OFS_W;

  logic [PC_INC_W-1:0] ofs_ext;
  logic [1:0]          skip_len;

  assign ofs_ext  = {{EXT_W{offset_i[OFS_W-1]}}, offset_i};
  assign skip_len = two_word_i ? 2'd3 : 2'd2;

  always_comb begin
    taken_o  = 1'b0;
    pc_inc_o = INC_ONE;
    cycles_o = CYC_W'(1);
    if (is_branch_i && br_hit_i) begin
      taken_o  = 1'b1;
      pc_inc_o = ofs_ext + INC_ONE;
      cycles_o = CYC_W'(2);
    end else if (is_skip_i && skip_hit_i) begin
      taken_o  = 1'b1;
      pc_inc_o = PC_INC_W'(skip_len);
      cycles_o = CYC_W'(skip_len);
    end
  end
endmodule

// File: rtl/bse_eval.sv
module bse_eval import bse_pkg::*; #(
  parameter int SREG_W   = 8,
  parameter int IDX_W    = $clog2(SREG_W),
  parameter int CLS_W    = 4,
  parameter int CC_W     = 4,
  parameter int OFS_W    = 7,
  parameter int PC_INC_W = 16,
  parameter int CYC_W    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [CLS_W-1:0]    class_i,
  input  logic [SREG_W-1:0]   sreg_i,
  input  logic [IDX_W-1:0]    bit_idx_i,
  input  logic [CC_W-1:0]     cond_i,
  input  logic [SREG_W-1:0]   test_byte_i,
  input  logic                regs_eq_i,
  input  logic                next_two_word_i,
  input  logic [OFS_W-1:0]    offset_i,
  output logic                valid_o,
  output logic                taken_o,
  output logic [PC_INC_W-1:0] pc_inc_o,
  output logic [CYC_W-1:0]    cycles_o
);
  logic                is_branch, br_hit, is_skip, skip_hit;
  logic                taken_d;
  logic [PC_INC_W-1:0] pc_inc_d;
  logic [CYC_W-1:0]    cycles_d;

  bse_branch_cond #(
    .SREG_W(SREG_W), .IDX_W(IDX_W), .CLS_W(CLS_W), .CC_W(CC_W)
  ) u_branch (
    .class_i     (class_i),
    .sreg_i      (sreg_i),
    .bit_idx_i   (bit_idx_i),
    .cond_i      (cond_i),
    .is_branch_o (is_branch),
    .hit_o       (br_hit)
  );

  bse_skip_cond #(
    .SREG_W(SREG_W), .IDX_W(IDX_W), .CLS_W(CLS_W)
  ) u_skip (
    .class_i     (class_i),
    .test_byte_i (test_byte_i),
    .bit_idx_i   (bit_idx_i),
    .regs_eq_i   (regs_eq_i),
    .is_skip_o   (is_skip),
    .hit_o       (skip_hit)
  );

  bse_cost #(
    .OFS_W(OFS_W), .PC_INC_W(PC_INC_W), .CYC_W(CYC_W)
  ) u_cost (
    .is_branch_i (is_branch),
    .br_hit_i    (br_hit),
    .is_skip_i   (is_skip),
    .skip_hit_i  (skip_hit),
    .two_word_i  (next_two_word_i),
    .offset_i    (offset_i),
    .taken_o     (taken_d),
    .pc_inc_o    (pc_inc_d),
    .cycles_o    (cycles_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      taken_o  <= 1'b0;
      pc_inc_o <= '0;
      cycles_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o  <= taken_d;
        pc_inc_o <= pc_inc_d;
        cycles_o <= cycles_d;
      end
    end
  end
endmodule

// File: rtl/bse_eval_chk.sv
module bse_eval_chk #(
  parameter int CLS_W    = 4,
  parameter int PC_INC_W = 16,
  parameter int CYC_W    = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [CLS_W-1:0]    class_i,
  input logic                regs_eq_i,
  input logic                valid_o,
  input logic                taken_o,
  input logic [PC_INC_W-1:0] pc_inc_o,
  input logic [CYC_W-1:0]    cycles_o
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !taken_o && cycles_o == '0));

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(taken_o) && $stable(pc_inc_o) && $stable(cycles_o)));

  a_r7_not_taken_cost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !taken_o) |-> (cycles_o == CYC_W'(1) && pc_inc_o == PC_INC_W'(1)));

  a_r10_taken_cost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o) |-> (cycles_o == CYC_W'(2) || cycles_o == CYC_W'(3)));

  a_r10_three_cycle_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cycles_o == CYC_W'(3)) |-> pc_inc_o == PC_INC_W'(3));

  a_r8_compare_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == CLS_W'(4)) |=> taken_o == $past(regs_eq_i));
endmodule

bind bse_eval bse_eval_chk #(
  .CLS_W(CLS_W), .PC_INC_W(PC_INC_W), .CYC_W(CYC_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .class_i   (class_i),
  .regs_eq_i (regs_eq_i),
  .valid_o   (valid_o),
  .taken_o   (taken_o),
  .pc_inc_o  (pc_inc_o),
  .cycles_o  (cycles_o)
);

// File: tb/bse_eval_tb.sv
module bse_eval_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  class_i = '0;
  logic [7:0]  sreg_i = '0;
  logic [2:0]  bit_idx_i = '0;
  logic [3:0]  cond_i = '0;
  logic [7:0]  test_byte_i = '0;
  logic        regs_eq_i = 1'b0;
  logic        next_two_word_i = 1'b0;
  logic [6:0]  offset_i = '0;
  logic        valid_o, taken_o;
  logic [15:0] pc_inc_o;
  logic [1:0]  cycles_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5ns clk_i = ~clk_i;

  bse_eval u_dut (
    .clk_i, .rst_ni, .valid_i, .class_i, .sreg_i, .bit_idx_i, .cond_i,
    .test_byte_i, .regs_eq_i, .next_two_word_i, .offset_i,
    .valid_o, .taken_o, .pc_inc_o, .cycles_o
  );

  // behavioural reference
  function automatic bit ref_taken(int cls, logic [7:0] s, int idx, int cc,
                                   logic [7:0] tb, bit eq);
    bit c = s[0], z = s[1], n = s[2], v = s[3], h = s[5], t = s[6];
    case (cls)
      1: return s[idx];
      2: return !s[idx];
      3: case (cc)
           0: return z;        1: return !z;
           2: return c;        3: return !c;
           4: return c;        5: return !c;
           6: return n;        7: return !n;
           8: return n != v;   9: return n == v;
           10: return h;       11: return !h;
           12: return t;       13: return !t;
           14: return v;       default: return !v;
         endcase
      4: return eq;
      5, 7: return !tb[idx];
      6, 8: return tb[idx];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string req, bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(int cls, logic [7:0] s, int idx, int cc, logic [7:0] tb,
                       bit eq, bit tw, logic [6:0] ofs, string req);
    bit          e_tk;
    int          e_cyc;
    logic [15:0] e_inc;
    valid_i = 1'b1; class_i = 4'(cls); sreg_i = s; bit_idx_i = 3'(idx);
    cond_i = 4'(cc); test_byte_i = tb; regs_eq_i = eq; next_two_word_i = tw;
    offset_i = ofs;
    e_tk  = ref_taken(cls, s, idx, cc, tb, eq);
    e_cyc = 1; e_inc = 16'd1;
    if (e_tk && cls >= 1 && cls <= 3) begin
      e_cyc = 2;
      e_inc = 16'($signed(ofs)) + 16'd1;
    end else if (e_tk) begin
      e_cyc = tw ? 3 : 2;
      e_inc = 16'(e_cyc);
    end
    @(negedge clk_i);
    check(req, valid_o == 1'b1, "valid_o", valid_o, 1);
    check(req, taken_o == e_tk, "taken_o", taken_o, e_tk);
    check(req, pc_inc_o == e_inc, "pc_inc_o", pc_inc_o, e_inc);
    check(req, cycles_o == 2'(e_cyc), "cycles_o", cycles_o, e_cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", valid_o == 0, "valid_o", valid_o, 0);
    check("R1", taken_o == 0, "taken_o", taken_o, 0);
    check("R1", pc_inc_o == 0, "pc_inc_o", pc_inc_o, 0);
    check("R1", cycles_o == 0, "cycles_o", cycles_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 generic status-bit branches
    for (int s = 0; s < 256; s++)
      for (int i = 0; i < 8; i++) begin
        apply(1, 8'(s), i, 0, 8'h00, 0, 0, 7'(s + i), "R3");
        apply(2, 8'(s), i, 0, 8'hff, 0, 1, 7'(s - i), "R3");
      end

    // R4 R5 R6 named conditions over every status byte
    for (int cc = 0; cc < 16; cc++)
      for (int s = 0; s < 256; s++)
        apply(3, 8'(s), 7 - (s % 8), cc, 8'(~s), s[0], s[1], 7'(s * 3 + cc),
              cc < 8 ? (cc < 8 && cc >= 8 ? "R5" : "R4") : (cc < 10 ? "R5" : "R6"));

    // R7 offset extremes
    apply(3, 8'h02, 0, 0, 8'h00, 0, 0, 7'h40, "R7");
    apply(3, 8'h02, 0, 0, 8'h00, 0, 0, 7'h3f, "R7");
    apply(3, 8'h02, 0, 0, 8'h00, 0, 0, 7'h7f, "R7");
    apply(3, 8'h00, 0, 0, 8'h00, 0, 0, 7'h40, "R7");

    // R8 compare-skip
    for (int k = 0; k < 4; k++)
      apply(4, 8'hff, 0, 0, 8'h00, k[0], k[1], 7'h55, "R8");

    // R9 R10 bit skips with both instruction lengths
    for (int cls = 5; cls <= 8; cls++)
      for (int b = 0; b < 256; b++)
        for (int i = 0; i < 8; i++)
          apply(cls, 8'(~b), i, i, 8'(b), 1, (b + i) % 2 == 1, 7'(b),
                i % 2 == 0 ? "R9" : "R10");

    // R11 idle classes ignore flags and offset
    for (int cls = 0; cls < 16; cls++)
      if (cls == 0 || cls > 8)
        for (int s = 0; s < 256; s += 51)
          apply(cls, 8'(s), s % 8, s % 16, 8'(s), 1, 1, 7'h3f, "R11");

    // R2 idle cycles hold results
    apply(3, 8'h02, 0, 0, 8'h00, 0, 0, 7'h10, "R2");
    valid_i = 1'b0; class_i = 4'd4; regs_eq_i = 1'b1; next_two_word_i = 1'b1;
    sreg_i = 8'h00; offset_i = 7'h00;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check("R2", valid_o == 0, "valid_o idle", valid_o, 0);
      check("R2", taken_o == 1, "taken_o held", taken_o, 1);
      check("R2", pc_inc_o == 16'h11, "pc_inc_o held", pc_inc_o, 16'h11);
      check("R2", cycles_o == 2, "cycles_o held", cycles_o, 2);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule